// File: doc/BRIEF.md
# PFM Pulse Timing Controller

This block makes the two gate commands of a synchronous buck stage running in pulse-frequency mode with diode emulation. It waits in an idle state with both switches off. When the output comparator reports that the output has sagged to its lower threshold, it fires one pulse: the high-side switch conducts for a programmed number of clocks, both switches rest for a short dead gap, and the low-side switch then conducts until the zero-current detector reports that the inductor has emptied. The controller then returns to idle. The off-time is therefore not timed by the block; the output voltage decides when the next pulse starts.

For a fixed on-time the pulse rate grows in proportion to the load current. A window monitor counts pulse starts over a fixed number of clocks and raises a request to leave PFM for PWM when the count in a window exceeds a programmable limit. A low-side watchdog stops a pulse whose zero-current event never arrives, and the on-time is clamped because output ripple grows with the square of the on-time.

Top module: `pfm_pulse_ctrl`

## Requirements
- R1: While reset is held and just after it, `hs_gate`, `ls_gate`, `ls_timeout` and `pwm_req` are all 0.
- R2: With `en` high, a clock edge that finds the controller idle and `vout_low` high starts a pulse; `hs_gate` is high from the next cycle for exactly the effective on-time.
- R3: The effective on-time is `ton_cfg` clamped to the range 1 to TON_MAX (default 200): a value of 0 gives 1 cycle, a value above TON_MAX gives TON_MAX cycles.
- R4: Between the fall of `hs_gate` and the rise of `ls_gate` both gates are low for exactly max(`dt_cfg`, 1) cycles; the two gates are never high in the same cycle.
- R5: `ls_gate` stays high until a clock edge samples `zc` high during the low-side phase; `ls_gate` is low from the following cycle, so a `zc` first driven high after the k-th low-side cycle gives a low-side width of k cycles.
- R6: If `zc` is not sampled high within LS_MAX (default 64) low-side cycles, `ls_gate` drops after exactly LS_MAX cycles and `ls_timeout` goes to 1; a `zc` sampled on the last allowed edge wins and sets no timeout. `ls_timeout` holds until the next pulse start, where it returns to 0.
- R7: `zc` has no effect outside the low-side phase, and `vout_low` has no effect outside the idle state: a `zc` held high through the high-side and dead phases leaves their widths unchanged and ends the low-side phase after one cycle.
- R8: While `en` is low, both gates are low in that same cycle, the controller returns to idle at the next edge, `vout_low` starts nothing, and `pwm_req` and `ls_timeout` are 0.
- R9: Counting from the first edge with `en` high, every block of WIN_CLKS (default 256) edges forms one window; at the last edge of a window `pwm_req` becomes 1 if the pulse starts in that window exceed `rate_lim`, else 0, and between those edges `pwm_req` does not change while `en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| en | input | 1 | PFM enable; low forces both gates off and clears the monitor |
| vout_low | input | 1 | Comparator flag: output at or below its lower threshold |
| zc | input | 1 | Zero-current flag for the inductor |
| ton_cfg | input | TON_W (8) | Requested on-time in clocks |
| dt_cfg | input | DT_W (4) | Requested dead gap in clocks |
| rate_lim | input | RATE_W (8) | Pulse count per window above which PWM is requested |
| hs_gate | output | 1 | High-side gate command |
| ls_gate | output | 1 | Low-side gate command |
| ls_timeout | output | 1 | Set when the low-side phase was ended by its watchdog |
| pwm_req | output | 1 | Request to return to PWM mode |

## Verification
The embedded properties watch on every cycle that the low side is only ever entered from the dead gap, that a pulse only begins from idle with the comparator flag set, that a low enable sends the machine to idle, that the high-side run never passes the on-time cap, that the low-side counter stays in range, that the timeout flag rises only as the low side drops, and that the PWM request moves only at window ends or on disable. Exact widths of each phase under clamping, the precedence of a late zero-current event over the watchdog, the clearing of the timeout flag at the next pulse, and the exact threshold behaviour of the rate window (limit pulses versus limit plus one) can only be shown by the bench's scenarios, which measure them at the ports.

// File: rtl/pfm_pkg.sv
package pfm_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HIGH = 2'd1,
    PH_DEAD = 2'd2,
    PH_LOW  = 2'd3
  } pfm_phase_e;

  // Effective on-time: at least one clock, never above the ripple cap.
  function automatic int on_len(int req, int cap);
    if (req < 1) return 1;
    if (req > cap) return cap;
    return req;
  endfunction

  // Effective dead gap: at least one clock so the gates never touch.
  function automatic int gap_len(int req);
    return (req < 1) ? 1 : req;
  endfunction

  // Rate decision at the end of a window.
  function automatic logic over_limit(int cnt, int lim);
    return cnt > lim;
  endfunction

endpackage

// File: rtl/pfm_phase_fsm.sv
module pfm_phase_fsm
  import pfm_pkg::*;
#(
  parameter int TON_W   = 8,
  parameter int DT_W    = 4,
  parameter int TON_MAX = 200,
  parameter int LS_MAX  = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             vout_low,
  input  logic             zc,
  input  logic [TON_W-1:0] ton_cfg,
  input  logic [DT_W-1:0]  dt_cfg,
  output pfm_phase_e       phase,
  output logic             pulse_start,
  output logic             timeout_flag
);

  localparam int TMR_W = (TON_W > DT_W) ? TON_W : DT_W;
  localparam int LS_W  = $clog2(LS_MAX + 1);

  logic [TMR_W-1:0] tmr;
  logic [LS_W-1:0]  ls_cnt;
  logic [TMR_W-1:0] ton_load;
  logic [TMR_W-1:0] dt_load;

  // Named internal events
  logic hs_done;
  logic dead_done;
  logic zc_end;
  logic ls_expire;

  always_comb begin
    ton_load    = TMR_W'(on_len(int'(ton_cfg), TON_MAX) - 1);
    dt_load     = TMR_W'(gap_len(int'(dt_cfg)) - 1);
    pulse_start = en && (phase == PH_IDLE) && vout_low;
    hs_done     = (phase == PH_HIGH) && (tmr == '0);
    dead_done   = (phase == PH_DEAD) && (tmr == '0);
    zc_end      = (phase == PH_LOW) && zc;
    ls_expire   = (phase == PH_LOW) && !zc && (ls_cnt == LS_W'(LS_MAX - 1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      phase        <= PH_IDLE;
      tmr          <= '0;
      ls_cnt       <= '0;
      timeout_flag <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (pulse_start) begin
            phase        <= PH_HIGH;
            tmr          <= ton_load;
            timeout_flag <= 1'b0;
          end
        end
        PH_HIGH: begin
          if (hs_done) begin
            phase <= PH_DEAD;
            tmr   <= dt_load;
          end else begin
            tmr <= tmr - TMR_W'(1);
          end
        end
        PH_DEAD: begin
          if (dead_done) begin
            phase  <= PH_LOW;
            ls_cnt <= '0;
          end else begin
            tmr <= tmr - TMR_W'(1);
          end
        end
        PH_LOW: begin
          if (zc_end) begin
            phase <= PH_IDLE;
          end else if (ls_expire) begin
            phase        <= PH_IDLE;
            timeout_flag <= 1'b1;
          end else begin
            ls_cnt <= ls_cnt + LS_W'(1);
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // Length of the current high-side run, for the cap check.
  logic [TON_W:0] hs_run;
  always_ff @(posedge clk) begin
    if (!rst_n) hs_run <= '0;
    else        hs_run <= (phase == PH_HIGH) ? hs_run + (TON_W+1)'(1) : '0;
  end

  // R3
  on_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_HIGH) |-> (hs_run < (TON_W+1)'(TON_MAX)));

  // R4
  dead_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase == PH_LOW) && $past(phase != PH_LOW)) |-> $past(phase == PH_DEAD));

  // R7
  start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase == PH_HIGH) && $past(phase == PH_IDLE)) |-> $past(vout_low && en));

  // R6
  ls_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ls_cnt < LS_W'(LS_MAX));

  // R8
  idle_on_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (phase == PH_IDLE));

endmodule

// File: rtl/pfm_rate_mon.sv
module pfm_rate_mon
  import pfm_pkg::*;
#(
  parameter int WIN_CLKS = 256,
  parameter int RATE_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              pulse_start,
  input  logic [RATE_W-1:0] rate_lim,
  output logic              pwm_req
);

  localparam int WIN_W = (WIN_CLKS > 1) ? $clog2(WIN_CLKS) : 1;

  logic [WIN_W-1:0]  win_cnt;
  logic [RATE_W-1:0] cnt;
  logic [RATE_W-1:0] cnt_next;
  logic              win_last;

  always_comb begin
    win_last = (win_cnt == WIN_W'(WIN_CLKS - 1));
    cnt_next = (pulse_start && (cnt != {RATE_W{1'b1}})) ? cnt + RATE_W'(1) : cnt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      win_cnt <= '0;
      cnt     <= '0;
      pwm_req <= 1'b0;
    end else if (win_last) begin
      win_cnt <= '0;
      cnt     <= '0;
      pwm_req <= over_limit(int'(cnt_next), int'(rate_lim));
    end else begin
      win_cnt <= win_cnt + WIN_W'(1);
      cnt     <= cnt_next;
    end
  end

  // R9
  req_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pwm_req) |-> $past(win_last || !en));

  // R8
  req_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !pwm_req);

endmodule

// File: rtl/pfm_pulse_ctrl.sv
module pfm_pulse_ctrl
  import pfm_pkg::*;
#(
  parameter int TON_W    = 8,
  parameter int DT_W     = 4,
  parameter int RATE_W   = 8,
  parameter int TON_MAX  = 200,
  parameter int LS_MAX   = 64,
  parameter int WIN_CLKS = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              vout_low,
  input  logic              zc,
  input  logic [TON_W-1:0]  ton_cfg,
  input  logic [DT_W-1:0]   dt_cfg,
  input  logic [RATE_W-1:0] rate_lim,
  output logic              hs_gate,
  output logic              ls_gate,
  output logic              ls_timeout,
  output logic              pwm_req
);

  pfm_phase_e phase;
  logic       pulse_start;

  pfm_phase_fsm #(
    .TON_W  (TON_W),
    .DT_W   (DT_W),
    .TON_MAX(TON_MAX),
    .LS_MAX (LS_MAX)
  ) fsm_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (en),
    .vout_low    (vout_low),
    .zc          (zc),
    .ton_cfg     (ton_cfg),
    .dt_cfg      (dt_cfg),
    .phase       (phase),
    .pulse_start (pulse_start),
    .timeout_flag(ls_timeout)
  );

  pfm_rate_mon #(
    .WIN_CLKS(WIN_CLKS),
    .RATE_W  (RATE_W)
  ) rate_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .pulse_start(pulse_start),
    .rate_lim   (rate_lim),
    .pwm_req    (pwm_req)
  );

  // Gates follow the phase, and a low enable cuts them in the same cycle.
  always_comb begin
    hs_gate = en && (phase == PH_HIGH);
    ls_gate = en && (phase == PH_LOW);
  end

  // R4
  gate_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_gate) |-> $past(!hs_gate));

  // R6
  timeout_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_timeout) |-> ($past(ls_gate) && !ls_gate));

endmodule

// File: tb/pfm_pulse_ctrl_tb_top.sv
module pfm_pulse_ctrl_tb_top;

  localparam int TON_MAX  = 200;
  localparam int LS_MAX   = 64;
  localparam int WIN_CLKS = 256;

  // {ton, dt, zc delay}; zc delay 0 or above LS_MAX means zc never comes
  localparam logic [23:0] VEC [0:7] = '{
    24'h0A0205, 24'h010101, 24'h000304, 24'hFF0103,
    24'h050006, 24'h030F40, 24'h040200, 24'h070441
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       vout_low = 1'b0;
  logic       zc = 1'b0;
  logic [7:0] ton_cfg = 8'd4;
  logic [3:0] dt_cfg = 4'd1;
  logic [7:0] rate_lim = 8'd3;
  logic       hs_gate, ls_gate, ls_timeout, pwm_req;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pfm_pulse_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .vout_low(vout_low), .zc(zc),
    .ton_cfg(ton_cfg), .dt_cfg(dt_cfg), .rate_lim(rate_lim),
    .hs_gate(hs_gate), .ls_gate(ls_gate), .ls_timeout(ls_timeout), .pwm_req(pwm_req)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // One pulse, measured at the ports on falling edges.
  task automatic run_pulse(input int ton, input int dt, input int zdel, input bit zc_pre,
                           output int hs_w, output int gap_w, output int ls_w,
                           output int overlap);
    bit first = 1'b1;
    hs_w = 0; gap_w = 0; ls_w = 0; overlap = 0;
    @(negedge clk);
    ton_cfg = 8'(ton); dt_cfg = 4'(dt); zc = zc_pre; vout_low = 1'b1;
    @(negedge clk);
    vout_low = 1'b0;
    for (int k = 0; k < 700; k++) begin
      if (first) begin
        chk("R6", "timeout cleared at pulse start", int'(ls_timeout), 0);
        first = 1'b0;
      end
      if (hs_gate && ls_gate) overlap++;
      if (hs_gate) hs_w++;
      if (!hs_gate && !ls_gate && hs_w > 0 && ls_w == 0) gap_w++;
      if (ls_gate) ls_w++;
      if (ls_w > 0 && !ls_gate) break;
      if (ls_gate && ls_w == zdel) zc = 1'b1;
      @(negedge clk);
    end
    zc = 1'b0;
  endtask

  // One rate window of WIN_CLKS edges with np spaced pulses.
  task automatic run_window(input int np, input int lim, inout int held);
    int rises = 0;
    bit prev = 1'b0;
    bit stable_ok = 1'b1;
    rate_lim = 8'(lim);
    for (int i = 1; i <= WIN_CLKS; i++) begin
      @(negedge clk);
      if (hs_gate && !prev) rises++;
      prev = hs_gate;
      if (i < WIN_CLKS && int'(pwm_req) != held) stable_ok = 1'b0;
      if (i == WIN_CLKS) begin
        held = (rises > lim) ? 1 : 0;
        chk("R9", "pwm_req held inside window", int'(stable_ok), 1);
        chk("R9", "pulses counted in window", rises, np);
        chk("R9", "pwm_req at window end", int'(pwm_req), held);
      end
      vout_low = ((i % 30) == 10 && (i / 30) < np) ? 1'b1 : 1'b0;
    end
    vout_low = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int hs_w, gap_w, ls_w, ov, held;
    int t, d, z, e_on, e_gap, e_ls, e_to;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", "hs_gate in reset", int'(hs_gate), 0);
    chk("R1", "ls_gate in reset", int'(ls_gate), 0);
    rst_n = 1'b1; en = 1'b1;
    @(negedge clk);
    chk("R1", "ls_timeout after reset", int'(ls_timeout), 0);
    chk("R1", "pwm_req after reset", int'(pwm_req), 0);

    // R2 R3 R4 R5 R6: table of pulse shapes
    foreach (VEC[n]) begin
      t = int'(VEC[n][23:16]); d = int'(VEC[n][15:8]); z = int'(VEC[n][7:0]);
      e_on  = (t == 0) ? 1 : ((t > TON_MAX) ? TON_MAX : t);
      e_gap = (d == 0) ? 1 : d;
      e_to  = (z == 0 || z > LS_MAX) ? 1 : 0;
      e_ls  = e_to ? LS_MAX : z;
      run_pulse(t, d, z, 1'b0, hs_w, gap_w, ls_w, ov);
      chk("R2", "high-side width", hs_w, e_on);
      chk("R4", "dead gap width", gap_w, e_gap);
      chk("R4", "gate overlap cycles", ov, 0);
      chk("R5", "low-side width", ls_w, e_ls);
      chk("R6", "timeout flag", int'(ls_timeout), e_to);
      repeat (2) @(negedge clk);
    end

    // R7: zc held high in idle starts nothing, and through high/dead changes nothing
    zc = 1'b1;
    repeat (4) begin
      @(negedge clk);
      chk("R7", "gates idle with zc high", int'(hs_gate || ls_gate), 0);
    end
    run_pulse(6, 2, 0, 1'b1, hs_w, gap_w, ls_w, ov);
    chk("R7", "high-side width with zc held", hs_w, 6);
    chk("R7", "dead gap with zc held", gap_w, 2);
    chk("R7", "low-side width with zc held", ls_w, 1);
    chk("R7", "no timeout with zc held", int'(ls_timeout), 0);

    // R8: disable mid pulse
    @(negedge clk);
    ton_cfg = 8'd50; dt_cfg = 4'd1; vout_low = 1'b1;
    @(negedge clk);
    vout_low = 1'b0;
    repeat (4) @(negedge clk);
    chk("R8", "hs_gate before disable", int'(hs_gate), 1);
    en = 1'b0;
    #1;
    chk("R8", "gates cut at once", int'(hs_gate || ls_gate), 0);
    vout_low = 1'b1;
    repeat (6) begin
      @(negedge clk);
      chk("R8", "no pulse while disabled", int'(hs_gate || ls_gate), 0);
    end
    vout_low = 1'b0;
    en = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk("R8", "idle after re-enable", int'(hs_gate || ls_gate), 0);
    end

    // R9: rate windows, aligned by a one-cycle disable
    ton_cfg = 8'd2; dt_cfg = 4'd1; zc = 1'b1;
    @(negedge clk); en = 1'b0;
    @(negedge clk); en = 1'b1;
    held = 0;
    run_window(3, 3, held);
    run_window(4, 3, held);
    run_window(3, 3, held);
    run_window(5, 3, held);
    chk("R9", "request raised before disable", int'(pwm_req), 1);
    en = 1'b0;
    @(negedge clk);
    chk("R8", "pwm_req cleared by disable", int'(pwm_req), 0);
    zc = 1'b0;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule